// File: doc/BRIEF.md
# Interrupt cause register with completion holdoff

This block collects ten event pulses from a network controller into a cause register. Software reads that register to find out what happened, and the read clears it. An enable mask selects which causes may drive the single interrupt line. Software changes the mask through two write addresses: one sets mask bits and the other clears them. Because of this, no read-modify-write of the mask is ever needed.

Three of the causes can be delayed by a holdoff timer before they are posted: transmit done, receive done on queue 0 and receive done on queue 1. The holdoff lets a burst of completions merge into one interrupt. The transmit holdoff is a plain tick count. The receive holdoff is a tick count together with an enable flag in bit 31 of its register, and the two receive-done causes each have their own timer loaded from that shared setting. One holdoff tick equals TICK_DIV system clocks. Each timer starts on the first completion it sees while idle. When it expires, the cause bit is set.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, the cause register and the mask read 0, irq_o is 0, the transmit holdoff register reads 128 and the receive holdoff register reads 0.
- R2: A pulse on evt_i[b] sets cause bit b, and that bit is readable after the next clock edge. Causes that are posted without delay sit at these bits: 1 tx empty, 2 link change, 3 rx symbol error, 4 rx queue 0 empty, 5 rx queue 1 empty, 9 bus error. Causes that can be held off sit at these bits: 0 tx done, 7 rx done queue 0, 8 rx done queue 1. Bit 6 and bits 31:10 always read 0.
- R3: A read of address 0 returns the cause value on rdata_o in the same cycle and clears the register, so an immediate second read returns 0.
- R4: An event posted in the same cycle as a cause read is not lost. It appears in the next read.
- R5: Writing address 1 ORs the implemented bits of wdata_i (mask 0x3BF) into the mask. Writing address 2 clears the mask bits that are 1 in wdata_i, so writing all ones clears the whole mask. The mask reads back at address 1 and at address 2.
- R6: irq_o is high exactly when some cause bit and its mask bit are both 1. A cause that arrives while its mask bit is 0 stays latched and raises irq_o once it is enabled.
- R7: With a transmit holdoff of N (address 4, bits 15:0, N > 0; reset value 128), the tx done cause becomes visible no earlier than (N-1)*TICK_DIV+1 clocks and no later than N*TICK_DIV clocks after the event edge.
- R8: Completions that arrive while a holdoff is pending neither restart it nor post a second cause once it has expired.
- R9: The receive holdoff (address 3: bit 31 enable, bits 15:0 count) delays rx done causes 7 and 8 in the same way as R7. If the flag is 0 or the count is 0, those causes are posted immediately.
- R10: A transmit holdoff count of 0 posts tx done immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe; a read of address 0 clears the causes |
| rdata_o | output | 32 | Read data for addr_i, valid while rd_i is high |
| evt_i | input | 10 | One event pulse per cause bit |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench targets a cause read that coincides with a new event. A design that clears after the OR would drop that event, and the following read would return 0. It measures holdoff expiry against an earliest bound and a latest bound for short counts and for the 128-tick default. A timer that counts clocks instead of ticks, or that is off by a whole tick, falls outside one of those bounds. It sends extra completions during a pending holdoff and checks two things: that the interrupt still arrives by the original deadline, which a timer that restarts would miss, and that no second cause follows after the clearing read. Random event, read and mask traffic with everything set to immediate posting is compared against a bench model of the cause register, the mask and irq_o.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int CAUSE_W     = 10;
  localparam int B_TX_DONE   = 0;
  localparam int B_TX_EMPTY  = 1;
  localparam int B_LINK      = 2;
  localparam int B_RX_SYMERR = 3;
  localparam int B_RX0_EMPTY = 4;
  localparam int B_RX1_EMPTY = 5;
  localparam int B_RX0_DONE  = 7;
  localparam int B_RX1_DONE  = 8;
  localparam int B_BUS_ERR   = 9;
  localparam int N_LANES     = 3;

  localparam logic [CAUSE_W-1:0] CAUSE_IMPL = 10'h3BF;
  localparam logic [CAUSE_W-1:0] HELD_BITS  = 10'h181;

  typedef enum logic [2:0] {
    A_CAUSE  = 3'd0,
    A_MSET   = 3'd1,
    A_MCLR   = 3'd2,
    A_RXHOLD = 3'd3,
    A_TXHOLD = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = (cnt_q == LAST);

  // R7: ticks are spaced by the divider, never back to back
  generate
    if (DIV > 1) begin : g_gap
      a_r7_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int HOLD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              evt_i,
  input  logic [HOLD_W-1:0] delay_i,
  output logic              post_o
);
  logic              pending_q;
  logic [HOLD_W-1:0] cnt_q;
  logic              imm;
  logic              expire;

  assign imm    = (delay_i == '0);
  assign expire = pending_q & tick_i & (cnt_q <= HOLD_W'(1));
  // a delay reprogrammed to zero while pending flushes at once
  assign post_o = expire | (imm & (evt_i | pending_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else if (post_o) begin
      pending_q <= 1'b0;
    end else if (evt_i && !pending_q) begin
      pending_q <= 1'b1;
      cnt_q     <= delay_i;
    end else if (pending_q && tick_i) begin
      cnt_q <= cnt_q - HOLD_W'(1);
    end
  end

  // R8: later completions never reload a running timer
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !tick_i && !post_o) |=> (pending_q && $stable(cnt_q)));

  // R7: a held completion is never posted on a cycle without a tick
  a_r7_post_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_o && !imm) |-> tick_i);
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int HOLD_W      = 16,
  parameter int TICK_DIV    = 4,
  parameter int TX_HOLD_RST = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rd_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [CAUSE_W-1:0] evt_i,
  output logic               irq_o
);
  localparam int FLAG_BIT = DATA_W - 1;

  logic [CAUSE_W-1:0] cause_q, mask_q, post_vec;
  logic               rx_flag_q;
  logic [HOLD_W-1:0]  rx_cnt_q, tx_cnt_q, rx_delay;
  logic               tick;
  logic [N_LANES-1:0] lane_evt, lane_post;
  logic               rd_cause, wr_set, wr_clr, wr_rx, wr_tx;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[FLAG_BIT-1:HOLD_W];

  assign rd_cause = rd_i && (addr_i == ADDR_W'(A_CAUSE));
  assign wr_set   = wr_i && (addr_i == ADDR_W'(A_MSET));
  assign wr_clr   = wr_i && (addr_i == ADDR_W'(A_MCLR));
  assign wr_rx    = wr_i && (addr_i == ADDR_W'(A_RXHOLD));
  assign wr_tx    = wr_i && (addr_i == ADDR_W'(A_TXHOLD));

  assign rx_delay = rx_flag_q ? rx_cnt_q : '0;

  irq_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign lane_evt = {evt_i[B_RX1_DONE], evt_i[B_RX0_DONE], evt_i[B_TX_DONE]};

  generate
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      irq_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .evt_i   (lane_evt[g]),
        .delay_i ((g == 0) ? tx_cnt_q : rx_delay),
        .post_o  (lane_post[g])
      );
    end
  endgenerate

  always_comb begin
    post_vec             = evt_i & CAUSE_IMPL & ~HELD_BITS;
    post_vec[B_TX_DONE]  = lane_post[0];
    post_vec[B_RX0_DONE] = lane_post[1];
    post_vec[B_RX1_DONE] = lane_post[2];
  end

  // read-clear happens before the OR so a same-cycle event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (rd_cause ? '0 : cause_q) | post_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (wr_set) mask_q <= mask_q | (wdata_i[CAUSE_W-1:0] & CAUSE_IMPL);
    else if (wr_clr) mask_q <= mask_q & ~wdata_i[CAUSE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_flag_q <= 1'b0;
      rx_cnt_q  <= '0;
      tx_cnt_q  <= HOLD_W'(TX_HOLD_RST);
    end else begin
      if (wr_rx) begin
        rx_flag_q <= wdata_i[FLAG_BIT];
        rx_cnt_q  <= wdata_i[HOLD_W-1:0];
      end
      if (wr_tx) tx_cnt_q <= wdata_i[HOLD_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CAUSE):                   rdata_o[CAUSE_W-1:0] = cause_q;
      ADDR_W'(A_MSET), ADDR_W'(A_MCLR):   rdata_o[CAUSE_W-1:0] = mask_q;
      ADDR_W'(A_RXHOLD): begin
        rdata_o[FLAG_BIT]   = rx_flag_q;
        rdata_o[HOLD_W-1:0] = rx_cnt_q;
      end
      ADDR_W'(A_TXHOLD):                  rdata_o[HOLD_W-1:0] = tx_cnt_q;
      default:                            rdata_o = '0;
    endcase
  end

  assign irq_o = |(cause_q & mask_q);

  // R4: an event coinciding with a clearing read is retained
  a_r4_keep_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cause && (post_vec != '0)) |=> (cause_q != '0));

  // R3: a read with nothing arriving leaves the register empty
  a_r3_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cause && (post_vec == '0)) |=> (cause_q == '0));

  // R5: a clear write removes every addressed mask bit
  a_r5_clear_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((mask_q & $past(wdata_i[CAUSE_W-1:0])) == '0));

  // R6: the line stays low while the mask is empty
  a_r6_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/sim_irq_cause_ctrl.sv
module sim_irq_cause_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam logic [9:0] IMPL = 10'h3BF;
  localparam logic [9:0] HELD = 10'h181;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic [9:0]  evt_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_cause_ctrl #(.TICK_DIV(DIV)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o), .evt_i(evt_i),
    .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [9:0] next_cause(logic [9:0] c, logic rd, logic [9:0] e);
    return (rd ? 10'h0 : c) | (e & IMPL);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    cyc();
    wr_i = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    cyc();
    rd_i = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] e);
    evt_i = e;
    cyc();
    evt_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [9:0]  exp_c, exp_m, e;
    logic        r;
    int          k;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rreg(3'd0, d); chk("R1 cause", d, 32'd0);
    rreg(3'd1, d); chk("R1 mask", d, 32'd0);
    rreg(3'd4, d); chk("R1 txhold", d, 32'd128);
    rreg(3'd3, d); chk("R1 rxhold", d, 32'd0);

    // R10: tx holdoff 0 gives immediate posting; rx flag off
    wreg(3'd4, 32'd0);
    wreg(3'd3, 32'd0);
    for (int b = 0; b < 10; b++) begin
      pulse(10'(1 << b));
      rreg(3'd0, d);
      if (b == 0) chk("R10 tx done immediate", d, 32'h1);
      else        chk("R2 cause bit position", d, {22'd0, IMPL & 10'(1 << b)});
    end
    // R9: rx done with flag off is immediate
    pulse(10'h180);
    rreg(3'd0, d); chk("R9 rx flag off immediate", d, 32'h180);

    // R3 read clears
    pulse(10'h214);
    rreg(3'd0, d); chk("R3 read value", d, 32'h214);
    rreg(3'd0, d); chk("R3 second read", d, 32'h0);

    // R4 event during read
    pulse(10'h008);
    evt_i = 10'h004;
    rreg(3'd0, d);
    evt_i = '0;
    chk("R4 read returns old", d, 32'h008);
    rreg(3'd0, d); chk("R4 event kept", d, 32'h004);

    // R5 mask set/clear
    wreg(3'd1, 32'hFFFF_FFFF);
    rreg(3'd1, d); chk("R5 set all", d, 32'h3BF);
    wreg(3'd2, 32'h0000_000F);
    rreg(3'd2, d); chk("R5 clear some", d, 32'h3B0);
    wreg(3'd1, 32'h1);
    rreg(3'd1, d); chk("R5 set one", d, 32'h3B1);
    wreg(3'd2, 32'hFFFF_FFFF);
    rreg(3'd1, d); chk("R5 clear all", d, 32'h0);

    // R6 masking
    pulse(10'h200);
    chk("R6 masked cause quiet", {31'd0, irq_o}, 32'd0);
    wreg(3'd1, 32'h200);
    chk("R6 enable raises irq", {31'd0, irq_o}, 32'd1);
    rreg(3'd0, d);
    chk("R6 read drops irq", {31'd0, irq_o}, 32'd0);
    wreg(3'd2, 32'hFFFF_FFFF);
    wreg(3'd1, 32'h004);
    pulse(10'h008);
    chk("R6 other bit no irq", {31'd0, irq_o}, 32'd0);
    rreg(3'd0, d);

    // R3 R6 random traffic, all immediate
    exp_c = '0;
    exp_m = 10'h004;
    for (int i = 0; i < 400; i++) begin
      e = 10'($urandom);
      r = ($urandom % 3) == 0;
      k = $urandom % 8;
      evt_i = e;
      rd_i = r;
      addr_i = r ? 3'd0 : ((k == 0) ? 3'd1 : 3'd2);
      wr_i = !r && (k < 2);
      wdata_i = $urandom;
      #1;
      if (r) chk("R3 random read", rdata_o, {22'd0, exp_c});
      cyc();
      exp_c = next_cause(exp_c, r, e);
      if (wr_i && addr_i == 3'd1) exp_m = exp_m | (wdata_i[9:0] & IMPL);
      if (wr_i && addr_i == 3'd2) exp_m = exp_m & ~wdata_i[9:0];
      evt_i = '0; rd_i = 1'b0; wr_i = 1'b0;
      chk("R6 random irq", {31'd0, irq_o}, {31'd0, |(exp_c & exp_m)});
    end
    rreg(3'd0, d);
    wreg(3'd2, 32'hFFFF_FFFF);

    // R7 tx holdoff of 5 ticks
    wreg(3'd1, 32'h181);
    wreg(3'd4, 32'd5);
    pulse(10'h001);
    repeat (16) cyc();
    chk("R7 not before bound", {31'd0, irq_o}, 32'd0);
    repeat (4) cyc();
    chk("R7 by deadline", {31'd0, irq_o}, 32'd1);
    rreg(3'd0, d); chk("R7 cause tx done", d, 32'h1);

    // R7 default 128
    wreg(3'd4, 32'd128);
    pulse(10'h001);
    repeat (127*DIV) cyc();
    chk("R7 default not early", {31'd0, irq_o}, 32'd0);
    repeat (DIV) cyc();
    chk("R7 default deadline", {31'd0, irq_o}, 32'd1);
    rreg(3'd0, d);

    // R8 merge without restart
    wreg(3'd4, 32'd5);
    pulse(10'h001);
    repeat (7) cyc();
    pulse(10'h001);
    repeat (5) cyc();
    pulse(10'h001);
    repeat (6) cyc();
    chk("R8 no restart", {31'd0, irq_o}, 32'd1);
    rreg(3'd0, d); chk("R8 merged cause", d, 32'h1);
    repeat (40) cyc();
    chk("R8 no second post", {31'd0, irq_o}, 32'd0);

    // R9 rx holdoff enabled, 3 ticks
    wreg(3'd3, 32'h8000_0003);
    rreg(3'd3, d); chk("R9 rxhold readback", d, 32'h8000_0003);
    pulse(10'h080);
    repeat (8) cyc();
    chk("R9 not before bound", {31'd0, irq_o}, 32'd0);
    repeat (4) cyc();
    chk("R9 by deadline", {31'd0, irq_o}, 32'd1);
    rreg(3'd0, d); chk("R9 rx0 cause", d, 32'h080);
    pulse(10'h100);
    rreg(3'd0, d); chk("R9 rx1 held", d, 32'h0);
    repeat (12) cyc();
    rreg(3'd0, d); chk("R9 rx1 posted", d, 32'h100);
    wreg(3'd3, 32'h8000_0000);
    pulse(10'h080);
    rreg(3'd0, d); chk("R9 zero count immediate", d, 32'h080);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule